// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block takes interrupt requests from three kinds of source: one non-maskable line, a set of on-chip peripheral lines, and a set of external request pins. Each maskable line carries its own 4-bit priority level. The block picks one winner and compares its level with the mask field of the current status word. It then waits until the CPU has finished its current operation and runs a fixed entry sequence on a memory bus. The sequence pushes the old status word and then the old program counter. It reads the handler address from a vector table, and it starts fetching the first handler instruction.

The decision takes one clock more for external pins than for the other sources. Wait states on the bus add directly to the entry time. A latency counter reports the number of cycles from the request to the first handler fetch, and these counts match closed formulas. The block takes no new request until the handler fetch of the current entry has been accepted by the bus.

The bus is a valid/ready interface, and only the memory side can apply back-pressure. Once the block raises `bus_valid`, it keeps the address, the direction and the write data unchanged until it samples `bus_ready` high at a rising edge. That edge completes the access. The memory may hold `bus_ready` low for any number of cycles. All other pins are plain levels or single-cycle pulses.

Top module: `exc_entry_seq`

## Requirements
- R1: Source numbering is as follows. Index 0 is the non-maskable line. Indices 1..N_ON are the on-chip lines, and the indices after those are the external pins. The non-maskable line is always accepted. A maskable line can win only when its level is strictly greater than the mask in `sr_in[7:4]`. With no eligible source, `take` stays low and no bus access occurs.
- R2: Among eligible maskable sources, the highest level wins. If levels are equal, the lowest index wins.
- R3: The decision occupies 2 cycles for the non-maskable and on-chip sources and 3 cycles for external pins. In the last of these cycles, `take` pulses high for one cycle and `take_src` gives the winner's index.
- R4: In the last decision cycle, the winner is checked again against the live inputs. If a maskable winner's line has dropped, or its level no longer exceeds the current mask, the block returns to idle with no `take` and no bus access.
- R5: Each consecutive cycle in which `cpu_busy` is high, counted from the last decision cycle, delays the start of the entry sequence by one cycle.
- R6: The accesses run in this fixed order:
  - a write of the old status word to SP-4;
  - a write of the old program counter to SP-8;
  - a read at VBR + 4 × vector number;
  - a read at the address returned by that read.
  The vector number is 11 for the non-maskable line, 72 + (index − 1) for an on-chip line, and 64 + (index − N_ON − 1) for an external pin.
- R7: While `bus_valid` is high and `bus_ready` is low, the address, the direction and the write data stay stable. Each access therefore lasts 1 + (wait cycles) cycles.
- R8: `fetch_start` pulses for exactly one cycle, in the first cycle of the handler fetch. The fetch starts L cycles after the request cycle, where L = decision + busy delay + 5 + (the cycle counts of the two pushes and the vector read). At that moment `lat_count` equals L.
- R9: From the cycle after `take`, `new_sr` equals the status word sampled at `take` with bits [7:4] replaced by the winner's level (15 for the non-maskable line). `new_sp` equals SP − 8.
- R10: While an entry sequence is in progress, no new request is taken. The next acceptance can start only after the handshake that completes the handler fetch.
- R11: After reset, `bus_valid`, `take` and `fetch_start` are low and `lat_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_req | input | 1 | Non-maskable request level |
| onchip_req | input | N_ON | On-chip request levels |
| onchip_lvl | input | 4*N_ON | Priority of each on-chip line, 4 bits per line |
| ext_req | input | N_EXT | External pin request levels |
| ext_lvl | input | 4*N_EXT | Priority of each external pin, 4 bits per pin |
| sr_in | input | XLEN | Current status word; mask in bits [7:4] |
| pc_in | input | XLEN | Program counter to push |
| sp_in | input | XLEN | Current stack pointer |
| vbr_in | input | XLEN | Vector table base |
| cpu_busy | input | 1 | CPU is still finishing its current operation |
| take | output | 1 | One-cycle pulse when a request is committed |
| take_src | output | IDX_W | Index of the committed source |
| new_sr | output | XLEN | Status word for the handler |
| new_sp | output | XLEN | Stack pointer after the two pushes |
| fetch_start | output | 1 | One-cycle pulse when the handler fetch begins |
| lat_count | output | LAT_W | Cycles from request to handler fetch |
| bus_valid | output | 1 | Bus request valid |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | XLEN | Bus address |
| bus_wdata | output | XLEN | Write data |
| bus_ready | input | 1 | Memory accepts or completes the access |
| bus_rdata | input | XLEN | Read data, valid together with bus_ready |

## Verification
The hardest situation to reach from the ports is the late withdrawal of a request. The mask must rise after the request has been seen but before the final decision cycle. The stimulus raises the mask on the falling edge one cycle after an external request appears, which lands inside the three-cycle window. A second hard case is a higher-priority request that arrives while an entry is in progress. Random trials overlap `cpu_busy` pulses of varying length with the decision window and draw a separate wait count for each bus access. This exercises every part of the latency sum.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEC,
    ST_WAIT,
    ST_GAP,
    ST_SRW,
    ST_PCW,
    ST_VRD,
    ST_FETCH
  } seq_st_e;

  localparam int          LVL_W   = 4;
  localparam logic [3:0]  TOP_LVL = 4'hF;

endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick
  import exc_entry_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDX_W = 4
) (
  input  logic                   nmi,
  input  logic [N_SRC-1:0]       req,
  input  logic [N_SRC*LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0]       mask,
  output logic                   found,
  output logic [IDX_W-1:0]       idx,
  output logic [LVL_W-1:0]       win_lvl
);

  logic hit;

  // Scan from the top index down; ">=" lets a lower index take over on a tie.
  always_comb begin
    hit     = 1'b0;
    idx     = '0;
    win_lvl = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i] && (lvl[i*LVL_W +: LVL_W] > mask) &&
          (!hit || (lvl[i*LVL_W +: LVL_W] >= win_lvl))) begin
        hit     = 1'b1;
        win_lvl = lvl[i*LVL_W +: LVL_W];
        idx     = IDX_W'(i + 1);
      end
    end
    if (nmi) begin
      idx     = '0;
      win_lvl = TOP_LVL;
    end
    found = nmi | hit;
  end

endmodule

// File: rtl/exc_lat_ctr.sv
module exc_lat_ctr #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= W'(1);
    end else if (run && (cnt != {W{1'b1}})) begin
      cnt <= cnt + W'(1);
    end
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int N_ON     = 4,
  parameter int N_EXT    = 4,
  parameter int XLEN     = 32,
  parameter int LAT_W    = 12,
  parameter int MASK_LSB = 4,
  parameter int VEC_NMI  = 11,
  parameter int VEC_ON   = 72,
  parameter int VEC_EXT  = 64,
  parameter int IDX_W    = $clog2(N_ON + N_EXT + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   nmi_req,
  input  logic [N_ON-1:0]        onchip_req,
  input  logic [N_ON*4-1:0]      onchip_lvl,
  input  logic [N_EXT-1:0]       ext_req,
  input  logic [N_EXT*4-1:0]     ext_lvl,
  input  logic [XLEN-1:0]        sr_in,
  input  logic [XLEN-1:0]        pc_in,
  input  logic [XLEN-1:0]        sp_in,
  input  logic [XLEN-1:0]        vbr_in,
  input  logic                   cpu_busy,
  output logic                   take,
  output logic [IDX_W-1:0]       take_src,
  output logic [XLEN-1:0]        new_sr,
  output logic [XLEN-1:0]        new_sp,
  output logic                   fetch_start,
  output logic [LAT_W-1:0]       lat_count,
  output logic                   bus_valid,
  output logic                   bus_write,
  output logic [XLEN-1:0]        bus_addr,
  output logic [XLEN-1:0]        bus_wdata,
  input  logic                   bus_ready,
  input  logic [XLEN-1:0]        bus_rdata
);

  localparam int N_M     = N_ON + N_EXT;
  localparam int GAP_PRE = 2;  // internal states before the first push
  localparam int GAP_MID = 1;  // internal state between later accesses
  localparam logic [XLEN-1:0] FIELD = XLEN'(4'hF) << MASK_LSB;

  logic [N_M-1:0]       all_req;
  logic [N_M*LVL_W-1:0] all_lvl;
  logic [LVL_W-1:0]     cur_mask;

  assign all_req  = {ext_req, onchip_req};
  assign all_lvl  = {ext_lvl, onchip_lvl};
  assign cur_mask = sr_in[MASK_LSB +: LVL_W];

  // Priority pick
  logic             found;
  logic [IDX_W-1:0] pick_idx;
  logic [LVL_W-1:0] pick_lvl;

  exc_prio_pick #(.N_SRC(N_M), .IDX_W(IDX_W)) u_pick (
    .nmi     (nmi_req),
    .req     (all_req),
    .lvl     (all_lvl),
    .mask    (cur_mask),
    .found   (found),
    .idx     (pick_idx),
    .win_lvl (pick_lvl)
  );

  // Sequencer state
  seq_st_e          st, gap_next;
  logic [1:0]       dec_cnt, gap_cnt;
  logic [IDX_W-1:0] win_idx;
  logic [LVL_W-1:0] win_lvl_q;
  logic [XLEN-1:0]  sr0, pc0, sp0, vec_addr_q, handler_q;
  logic             fetch_seen;

  // Vector number of the source being picked
  logic [7:0]      vec_num;
  logic            pick_ext;
  logic [XLEN-1:0] vec_addr;

  always_comb begin
    pick_ext = pick_idx > IDX_W'(N_ON);
    if (pick_idx == '0)
      vec_num = 8'(VEC_NMI);
    else if (!pick_ext)
      vec_num = 8'(VEC_ON + int'(pick_idx) - 1);
    else
      vec_num = 8'(VEC_EXT + int'(pick_idx) - N_ON - 1);
    vec_addr = vbr_in + (XLEN'(vec_num) << 2);
  end

  // Recheck of the held winner against the live inputs
  logic             chk_req;
  logic [LVL_W-1:0] chk_lvl;
  logic             still_ok;

  always_comb begin
    chk_req = 1'b0;
    chk_lvl = '0;
    for (int i = 0; i < N_M; i++) begin
      if (win_idx == IDX_W'(i + 1)) begin
        chk_req = all_req[i];
        chk_lvl = all_lvl[i*LVL_W +: LVL_W];
      end
    end
    still_ok = (win_idx == '0) || (chk_req && (chk_lvl > cur_mask));
  end

  logic last_dec;
  assign last_dec = (st == ST_DEC) && (dec_cnt == 2'd1);
  assign take     = last_dec && still_ok;
  assign take_src = win_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      gap_next   <= ST_IDLE;
      dec_cnt    <= '0;
      gap_cnt    <= '0;
      win_idx    <= '0;
      win_lvl_q  <= '0;
      sr0        <= '0;
      pc0        <= '0;
      sp0        <= '0;
      vec_addr_q <= '0;
      handler_q  <= '0;
      fetch_seen <= 1'b0;
      new_sr     <= '0;
      new_sp     <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (found) begin
            win_idx    <= pick_idx;
            win_lvl_q  <= pick_lvl;
            vec_addr_q <= vec_addr;
            dec_cnt    <= pick_ext ? 2'd2 : 2'd1;
            st         <= ST_DEC;
          end
        end
        ST_DEC: begin
          if (dec_cnt == 2'd1) begin
            if (still_ok) begin
              sr0      <= sr_in;
              pc0      <= pc_in;
              sp0      <= sp_in;
              new_sr   <= (sr_in & ~FIELD) | (XLEN'(win_lvl_q) << MASK_LSB);
              new_sp   <= sp_in - XLEN'(8);
              gap_cnt  <= 2'(GAP_PRE);
              gap_next <= ST_SRW;
              st       <= cpu_busy ? ST_WAIT : ST_GAP;
            end else begin
              st <= ST_IDLE;
            end
          end else begin
            dec_cnt <= dec_cnt - 2'd1;
          end
        end
        ST_WAIT: begin
          if (!cpu_busy) st <= ST_GAP;
        end
        ST_GAP: begin
          if (gap_cnt == 2'd1) st <= gap_next;
          else                 gap_cnt <= gap_cnt - 2'd1;
        end
        ST_SRW: begin
          if (bus_ready) begin
            gap_cnt  <= 2'(GAP_MID);
            gap_next <= ST_PCW;
            st       <= ST_GAP;
          end
        end
        ST_PCW: begin
          if (bus_ready) begin
            gap_cnt  <= 2'(GAP_MID);
            gap_next <= ST_VRD;
            st       <= ST_GAP;
          end
        end
        ST_VRD: begin
          if (bus_ready) begin
            handler_q <= bus_rdata;
            gap_cnt   <= 2'(GAP_MID);
            gap_next  <= ST_FETCH;
            st        <= ST_GAP;
          end
        end
        ST_FETCH: begin
          fetch_seen <= 1'b1;
          if (bus_ready) begin
            fetch_seen <= 1'b0;
            st         <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Bus request decode
  always_comb begin
    bus_valid = 1'b0;
    bus_write = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    unique case (st)
      ST_SRW: begin
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_addr  = sp0 - XLEN'(4);
        bus_wdata = sr0;
      end
      ST_PCW: begin
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_addr  = sp0 - XLEN'(8);
        bus_wdata = pc0;
      end
      ST_VRD: begin
        bus_valid = 1'b1;
        bus_addr  = vec_addr_q;
      end
      ST_FETCH: begin
        bus_valid = 1'b1;
        bus_addr  = handler_q;
      end
      default: ;
    endcase
  end

  assign fetch_start = (st == ST_FETCH) && !fetch_seen;

  exc_lat_ctr #(.W(LAT_W)) u_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   ((st == ST_IDLE) && found),
    .run   ((st != ST_IDLE) && (st != ST_FETCH)),
    .cnt   (lat_count)
  );

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int N_ON     = 4,
  parameter int N_EXT    = 4,
  parameter int XLEN     = 32,
  parameter int MASK_LSB = 4,
  parameter int IDX_W    = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_ON*4-1:0]    onchip_lvl,
  input logic [N_EXT*4-1:0]   ext_lvl,
  input logic [XLEN-1:0]      sr_in,
  input logic                 take,
  input logic [IDX_W-1:0]     take_src,
  input logic [XLEN-1:0]      new_sr,
  input logic                 fetch_start,
  input logic                 bus_valid,
  input logic                 bus_write,
  input logic [XLEN-1:0]      bus_addr,
  input logic [XLEN-1:0]      bus_wdata,
  input logic                 bus_ready
);

  localparam int N_M = N_ON + N_EXT;

  logic [N_M*4-1:0] lv_all;
  logic [3:0]       tl;

  assign lv_all = {ext_lvl, onchip_lvl};

  always_comb begin
    tl = 4'hF;
    for (int i = 0; i < N_M; i++)
      if (take_src == IDX_W'(i + 1)) tl = lv_all[i*4 +: 4];
  end

  // R1: a committed maskable source beats the current mask
  p_take_above_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_src != '0) |-> (tl > sr_in[MASK_LSB +: 4]));

  // R7: request held stable under back-pressure
  p_hold_under_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
                                   $stable(bus_write) && $stable(bus_wdata)));

  // R8: fetch start is a single-cycle pulse
  p_fetch_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |=> !fetch_start);

  // R6: handler fetch is a read on the bus
  p_fetch_is_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |-> (bus_valid && !bus_write));

  // R9: mask field takes the committed level
  p_mask_loaded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (new_sr[MASK_LSB +: 4] == $past(tl)));

  // R10: no commit while an access is outstanding
  p_no_take_in_flight_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !take);

endmodule

bind exc_entry_seq exc_entry_chk #(
  .N_ON(N_ON), .N_EXT(N_EXT), .XLEN(XLEN), .MASK_LSB(MASK_LSB), .IDX_W(IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .onchip_lvl  (onchip_lvl),
  .ext_lvl     (ext_lvl),
  .sr_in       (sr_in),
  .take        (take),
  .take_src    (take_src),
  .new_sr      (new_sr),
  .fetch_start (fetch_start),
  .bus_valid   (bus_valid),
  .bus_write   (bus_write),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_ready   (bus_ready)
);

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        nmi_req;
  logic [3:0]  onchip_req, ext_req;
  logic [15:0] onchip_lvl, ext_lvl;
  logic [31:0] sr_in, pc_in, sp_in, vbr_in;
  logic        cpu_busy;
  logic        take;
  logic [3:0]  take_src;
  logic [31:0] new_sr, new_sp;
  logic        fetch_start;
  logic [11:0] lat_count;
  logic        bus_valid, bus_write, bus_ready;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;

  always #10 clk = ~clk;

  exc_entry_seq u0 (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req),
    .onchip_req(onchip_req), .onchip_lvl(onchip_lvl),
    .ext_req(ext_req), .ext_lvl(ext_lvl),
    .sr_in(sr_in), .pc_in(pc_in), .sp_in(sp_in), .vbr_in(vbr_in),
    .cpu_busy(cpu_busy), .take(take), .take_src(take_src),
    .new_sr(new_sr), .new_sp(new_sp), .fetch_start(fetch_start),
    .lat_count(lat_count), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc++;

  // Output monitor
  int take_seen = 0, fs_seen = 0, take_cyc = 0, fs_cyc = 0;
  logic [3:0]  take_id;
  logic [11:0] fs_lat;
  always @(negedge clk) begin
    if (take)        begin take_seen++; take_cyc = cyc; take_id = take_src; end
    if (fetch_start) begin fs_seen++;   fs_cyc = cyc;   fs_lat = lat_count; end
  end

  // Memory responder with per-access wait counts
  int wt[0:3];
  int acc_no = 0, wcnt = 0;
  logic [31:0] cap_addr[0:3], cap_data[0:3];
  logic        cap_wr[0:3];
  always @(negedge clk) begin
    if (!rst_n || !bus_valid) begin
      bus_ready = 1'b0;
      wcnt = 0;
    end else if (!bus_ready) begin
      if (wcnt == wt[acc_no % 4]) begin
        bus_ready = 1'b1;
        bus_rdata = bus_write ? 32'h0 : (bus_addr ^ 32'h5A00_0000);
        cap_addr[acc_no % 4] = bus_addr;
        cap_data[acc_no % 4] = bus_wdata;
        cap_wr[acc_no % 4]   = bus_write;
        acc_no++;
      end else begin
        wcnt++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pick(bit n, logic [3:0] onr, logic [15:0] onl,
                              logic [3:0] exr, logic [15:0] exl, logic [3:0] m);
    int best = -1;
    int bl = -1;
    if (n) return 0;
    for (int i = 0; i < 8; i++) begin
      bit r;
      int l;
      r = (i < 4) ? onr[i] : exr[i-4];
      l = (i < 4) ? int'(onl[i*4 +: 4]) : int'(exl[(i-4)*4 +: 4]);
      if (r && l > int'(m) && l > bl) begin best = i + 1; bl = l; end
    end
    return best;
  endfunction

  function automatic int lvl_of(int id, logic [15:0] onl, logic [15:0] exl);
    if (id == 0) return 15;
    if (id <= 4) return int'(onl[(id-1)*4 +: 4]);
    return int'(exl[(id-5)*4 +: 4]);
  endfunction

  function automatic int vec_of(int id);
    if (id == 0) return 11;
    if (id <= 4) return 72 + id - 1;
    return 64 + id - 5;
  endfunction

  task automatic wait_cnt(ref int ctr, input int target, input int lim, output bit ok);
    ok = 0;
    for (int k = 0; k < lim; k++) begin
      @(posedge clk); #2;
      if (ctr >= target) begin ok = 1; break; end
    end
  endtask

  task automatic drop_reqs();
    @(negedge clk);
    nmi_req = 0; onchip_req = '0; ext_req = '0;
  endtask

  task automatic run_trial(input bit nmi_i, input logic [3:0] onr, input logic [15:0] onl,
                           input logic [3:0] exr, input logic [15:0] exl, input logic [3:0] msk,
                           input int bsy, input int w0, input int w1, input int w2, input int w3,
                           input string tag);
    int exp_id, d, xw, lat_e, c0;
    logic [31:0] sr_v, pc_v, sp_v, va, nsr;
    bit ok;
    @(negedge clk);
    wt[0] = w0; wt[1] = w1; wt[2] = w2; wt[3] = w3;
    acc_no = 0; take_seen = 0; fs_seen = 0;
    sr_v = ($urandom & 32'hFFFF_FF0F) | (32'(msk) << 4);
    pc_v = $urandom & 32'hFFFF_FFFC;
    sp_v = 32'h0000_8000 + ($urandom & 32'h0000_0FFC);
    sr_in = sr_v; pc_in = pc_v; sp_in = sp_v;
    nmi_req = nmi_i; onchip_req = onr; onchip_lvl = onl; ext_req = exr; ext_lvl = exl;
    c0 = cyc;
    if (bsy > 0) begin
      fork
        begin
          cpu_busy = 1'b1;
          repeat (bsy) @(posedge clk);
          @(negedge clk);
          cpu_busy = 1'b0;
        end
      join_none
    end
    exp_id = pick(nmi_i, onr, onl, exr, exl, msk);
    if (exp_id < 0) begin
      repeat (12) @(posedge clk); #2;
      chk({tag, " R1 masked: no take"}, 32'(take_seen), 0);
      chk({tag, " R1 masked: no bus access"}, 32'(acc_no), 0);
      drop_reqs();
      repeat (8) @(posedge clk);
      return;
    end
    d = (exp_id > 4) ? 3 : 2;
    xw = (bsy > d - 1) ? bsy - (d - 1) : 0;
    lat_e = d + xw + 5 + 3 + w0 + w1 + w2;
    va = 32'h0001_0000 + 32'(vec_of(exp_id)) * 4;
    nsr = (sr_v & ~32'hF0) | (32'(lvl_of(exp_id, onl, exl)) << 4);
    wait_cnt(take_seen, 1, 20, ok);
    chk({tag, " R3 take seen"}, 32'(ok), 1);
    chk({tag, " R2 winner index"}, 32'(take_id), 32'(exp_id));
    chk({tag, " R3 decision length"}, 32'(take_cyc - c0), 32'(d - 1));
    drop_reqs();
    wait_cnt(fs_seen, 1, 120, ok);
    chk({tag, " R8 fetch start seen"}, 32'(ok), 1);
    chk({tag, " R5 R8 latency at port"}, 32'(fs_cyc - c0), 32'(lat_e));
    chk({tag, " R8 lat_count"}, 32'(fs_lat), 32'(lat_e));
    wait_cnt(acc_no, 4, 20, ok);
    chk({tag, " R6 sr push"}, {cap_wr[0] ? 32'h1 : 32'h0} ^ cap_addr[0] ^ cap_data[0],
        32'h1 ^ (sp_v - 4) ^ sr_v);
    chk({tag, " R6 pc push"}, {cap_wr[1] ? 32'h1 : 32'h0} ^ cap_addr[1] ^ cap_data[1],
        32'h1 ^ (sp_v - 8) ^ pc_v);
    chk({tag, " R6 vector read addr"}, cap_addr[2], va);
    chk({tag, " R6 handler fetch addr"}, cap_addr[3], va ^ 32'h5A00_0000);
    chk({tag, " R9 new_sr"}, new_sr, nsr);
    chk({tag, " R9 new_sp"}, new_sp, sp_v - 8);
    repeat (3) @(posedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit ok;
    void'($urandom(32'h0000_2B67));
    rst_n = 0; nmi_req = 0; onchip_req = 0; ext_req = 0; onchip_lvl = 0; ext_lvl = 0;
    sr_in = 0; pc_in = 0; sp_in = 32'h8000; vbr_in = 32'h0001_0000; cpu_busy = 0;
    bus_ready = 0; bus_rdata = 0;
    wt[0] = 0; wt[1] = 0; wt[2] = 0; wt[3] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #2;
    chk("R11 bus_valid after reset", 32'(bus_valid), 0);
    chk("R11 take after reset", 32'(take), 0);
    chk("R11 fetch_start after reset", 32'(fetch_start), 0);
    chk("R11 lat_count after reset", 32'(lat_count), 0);

    // Directed corners
    run_trial(1, 4'b0001, 16'h000F, 4'b0000, 16'h0, 4'hF, 0, 0, 0, 0, 0, "nmi mask15 R1");
    run_trial(0, 4'b0001, 16'h0005, 4'b0000, 16'h0, 4'h5, 0, 0, 0, 0, 0, "equal to mask R1");
    run_trial(0, 4'b0100, 16'h0900, 4'b0001, 16'h0009, 4'h2, 0, 1, 0, 0, 0, "tie R2");
    run_trial(0, 4'b0000, 16'h0, 4'b1000, 16'hA000, 4'h0, 6, 3, 0, 2, 1, "ext busy R5");
    run_trial(0, 4'b0010, 16'h00C0, 4'b0000, 16'h0, 4'h1, 4, 0, 0, 0, 0, "onchip busy R5");

    // R4: mask raised inside the external decision window
    @(negedge clk);
    acc_no = 0; take_seen = 0; fs_seen = 0;
    wt[0] = 0; wt[1] = 0; wt[2] = 0; wt[3] = 0;
    sr_in = 32'h0000_0020; ext_req = 4'b0010; ext_lvl = 16'h0060;
    @(negedge clk);
    sr_in = 32'h0000_0070;
    repeat (12) @(posedge clk); #2;
    chk("R4 withdrawn: no take", 32'(take_seen), 0);
    chk("R4 withdrawn: no bus access", 32'(acc_no), 0);
    @(negedge clk);
    sr_in = 32'h0000_0020;
    wait_cnt(take_seen, 1, 10, ok);
    chk("R4 taken after mask lowered", 32'(take_id), 6);
    drop_reqs();
    wait_cnt(acc_no, 4, 60, ok);
    repeat (3) @(posedge clk);

    // R10: higher request arriving mid-sequence waits for the fetch handshake
    @(negedge clk);
    acc_no = 0; take_seen = 0; fs_seen = 0;
    wt[0] = 1; wt[1] = 1; wt[2] = 1; wt[3] = 1;
    sr_in = 32'h0; onchip_req = 4'b0001; onchip_lvl = 16'h0003;
    wait_cnt(take_seen, 1, 10, ok);
    @(negedge clk);
    onchip_req = 0; ext_req = 4'b0010; ext_lvl = 16'h00C0;
    wait_cnt(acc_no, 4, 80, ok);
    chk("R10 no take while in flight", 32'(take_seen), 1);
    wait_cnt(take_seen, 2, 10, ok);
    chk("R10 second take after fetch", 32'(ok), 1);
    chk("R10 second winner", 32'(take_id), 6);
    drop_reqs();
    wait_cnt(fs_seen, 2, 80, ok);
    wait_cnt(acc_no, 8, 20, ok);
    repeat (3) @(posedge clk);

    // Constrained random trials
    for (int t = 0; t < 40; t++) begin
      bit n;
      n = ($urandom % 8) == 0;
      run_trial(n, 4'($urandom), 16'($urandom), 4'($urandom), 16'($urandom),
                4'($urandom), int'($urandom % 6), int'($urandom % 4), int'($urandom % 4),
                int'($urandom % 4), int'($urandom % 4), "random R1");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule